// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This controller turns seven regulator channels on and off from a single active-low push-button and two hold lines driven by the host processor. A press from the off state starts the third rail first. Once that rail reports power-good, the first and second core rails come up at fixed millisecond offsets, and the processor is held in reset until a reset window has elapsed. The start is abandoned unless the processor raises its core-hold line before the button is let go. This protects against a press made by accident and against a processor that never finishes booting.

After a completed start, the core rails stay up as long as the core-hold line or the peripheral-enable line is high. The four peripheral rails follow the peripheral-enable line alone. A press during normal operation only raises an interrupt, because shutdown is left to software: it drops the peripheral enable and then the core hold. A standby-select input lowers the voltage choice of the three core rails while the system is running. Millisecond timing comes from a divider on the system clock, and the button passes through a synchronizer and a debounce filter before the sequencer sees it.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset all seven enables are low, the reset output is low, the interrupt output is high and the standby select is low. From the off state a debounced press enables the third rail only (rail_en_o = 7'b0000100, bit 0 being the first rail), and the reset output stays low.
- R2: The button is sampled through two flops, and its filtered level changes only after the synchronized level has differed from it for DEB_CYCLES consecutive clocks. A press shorter than that has no effect.
- R3: Counting from the clock edge at which the sequencer sees the third rail's power-good, the first rail is enabled after REG1_DLY_MS*TICK_DIV clocks and the second rail after REG2_DLY_MS*TICK_DIV clocks. The order is therefore third, then first, then second.
- R4: The reset output is released RST_MS*TICK_DIV clocks after that edge, and only if the third rail's power-good is still high at the expiry edge. Otherwise it stays low.
- R5: If the third rail's power-good falls during the staggered start, one clock later every enable is low and the reset output is low.
- R6: Before the reset release, if the filtered button is released while core hold is low, the start is aborted and every enable goes low.
- R7: In normal operation, the three core rails stay enabled while core hold, peripheral enable or the filtered button is high. Rails four to seven equal the peripheral-enable input, and they are never enabled while the reset output is low.
- R8: In normal operation, with core hold and peripheral enable both low and the button released, every enable goes low and the reset output goes low one clock later. The controller then waits for a new press.
- R9: The interrupt output is low exactly while the filtered button is pressed in normal operation, and high in every other state.
- R10: The standby-select output equals the standby input while in normal operation, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n_i | input | 1 | Push-button, low while pressed, asynchronous |
| reg3_pgood_i | input | 1 | Power-good of the third rail, synchronous |
| core_hold_i | input | 1 | Processor hold for the first three rails |
| periph_en_i | input | 1 | Processor enable for rails four to seven |
| stby_sel_i | input | 1 | Requests standby voltage on the core rails |
| rail_en_o | output | 7 | Regulator enables, bit n for rail n+1 |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| btn_irq_n_o | output | 1 | Active-low button status interrupt |
| stby_vsel_o | output | 1 | Standby voltage select for the core rails |

## Verification
The assertions assume that the power-good input is synchronous to the clock and that it changes only on clock edges. They also assume that the processor lines are driven to defined levels from reset onward. The stimulus changes every input on the falling clock edge and holds the button steady for longer than the debounce window, except for one deliberate short glitch. The timed checks take the power-good rise as their zero point. In normal operation the random part of the stimulus never lowers both hold lines together, so it never starts a shutdown unintentionally; shutdown is driven only by a directed step.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NUM_RAILS = 7;
  localparam int IDX_REG1  = 0;
  localparam int IDX_REG2  = 1;
  localparam int IDX_REG3  = 2;
  localparam int NUM_CORE  = 3;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_WAIT_PG = 2'd1,
    ST_STAGGER = 2'd2,
    ST_RUN     = 2'd3
  } seq_state_t;

  // A staggered rail is due once the elapsed milliseconds reach its delay.
  function automatic logic rail_due(input int unsigned ms_done,
                                    input int unsigned dly_ms);
    return ms_done >= dly_ms;
  endfunction

  // Counter width able to hold values 0..n-1 (minimum one bit).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pwrseq_ms_tick.sv
module pwrseq_ms_tick #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  import pwrseq_pkg::*;

  localparam int CW = cnt_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  assign tick_o = run_i && (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (!run_i || tick_o) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  // The divider restarts whenever the sequencer leaves the counting state.
  assert_tick_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_o || (TICK_DIV == 1));

endmodule

// File: rtl/pwrseq_btn_filter.sv
module pwrseq_btn_filter #(
  parameter int DEB_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  output logic pressed_o
);
  import pwrseq_pkg::*;

  localparam int DW = cnt_width(DEB_CYCLES);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);

  logic          sync1_q, sync2_q;
  logic          filt_q;
  logic [DW-1:0] deb_q;
  logic          sync_press;
  logic          mismatch;

  assign sync_press = !sync2_q;
  assign mismatch   = sync_press != filt_q;
  assign pressed_o  = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= btn_n_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      deb_q  <= '0;
    end else if (!mismatch) begin
      deb_q  <= '0;
    end else if (deb_q == DEB_LAST) begin
      filt_q <= sync_press;
      deb_q  <= '0;
    end else begin
      deb_q  <= deb_q + 1'b1;
    end
  end

  // The filtered level only moves toward a level the synchronizer already shows.
  assert_filter_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_press) == filt_q));

endmodule

// File: rtl/pwrseq_seq.sv
module pwrseq_seq #(
  parameter int RST_MS      = 20,
  parameter int REG1_DLY_MS = 2,
  parameter int REG2_DLY_MS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pressed_i,
  input  logic                           reg3_pgood_i,
  input  logic                           core_hold_i,
  input  logic                           periph_en_i,
  input  logic                           stby_sel_i,
  input  logic                           tick_i,
  output logic                           stagger_o,
  output logic [pwrseq_pkg::NUM_RAILS-1:0] rail_en_o,
  output logic                           cpu_rst_n_o,
  output logic                           btn_irq_n_o,
  output logic                           stby_vsel_o
);
  import pwrseq_pkg::*;

  localparam int MS_W = $clog2(RST_MS + 1);
  localparam int NUM_PERIPH = NUM_RAILS - NUM_CORE;

  seq_state_t      state_q, state_d;
  logic [MS_W-1:0] ms_q;

  // Named internal events.
  logic in_boot;
  logic in_run;
  logic boot_abort;
  logic pg_lost;
  logic timer_expire;
  logic shutdown_req;
  logic reg1_due, reg2_due;

  assign in_boot      = (state_q == ST_WAIT_PG) || (state_q == ST_STAGGER);
  assign in_run       = (state_q == ST_RUN);
  assign boot_abort   = in_boot && !pressed_i && !core_hold_i;
  assign pg_lost      = (state_q == ST_STAGGER) && !reg3_pgood_i;
  assign timer_expire = (state_q == ST_STAGGER) && tick_i &&
                        (ms_q == MS_W'(RST_MS - 1));
  assign shutdown_req = in_run && !pressed_i && !core_hold_i && !periph_en_i;
  assign reg1_due     = rail_due(int'(ms_q), REG1_DLY_MS);
  assign reg2_due     = rail_due(int'(ms_q), REG2_DLY_MS);
  assign stagger_o    = (state_q == ST_STAGGER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (pressed_i) state_d = ST_WAIT_PG;
      ST_WAIT_PG: begin
        if (boot_abort)        state_d = ST_OFF;
        else if (reg3_pgood_i) state_d = ST_STAGGER;
      end
      ST_STAGGER: begin
        if (pg_lost || boot_abort) state_d = ST_OFF;
        else if (timer_expire)     state_d = ST_RUN;
      end
      ST_RUN:     if (shutdown_req) state_d = ST_OFF;
      default:    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ms_q <= '0;
    else if (state_q != ST_STAGGER) ms_q <= '0;
    else if (tick_i)               ms_q <= ms_q + 1'b1;
  end

  // Output decode from the registered state.
  always_comb begin
    rail_en_o = '0;
    rail_en_o[IDX_REG3] = in_boot || in_run;
    rail_en_o[IDX_REG1] = in_run || (stagger_o && reg1_due);
    rail_en_o[IDX_REG2] = in_run || (stagger_o && reg2_due);
    rail_en_o[NUM_RAILS-1:NUM_CORE] = {NUM_PERIPH{in_run && periph_en_i}};
  end

  assign cpu_rst_n_o = in_run;
  assign btn_irq_n_o = !(in_run && pressed_i);
  assign stby_vsel_o = in_run && stby_sel_i;

  // Assertions
  assert_reg3_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_OFF && state_q != ST_OFF) |-> (rail_en_o == 7'b0000100));

  assert_core_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en_o[IDX_REG2] |-> (rail_en_o[IDX_REG1] && rail_en_o[IDX_REG3]));

  assert_release_pg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n_o) |-> $past(reg3_pgood_i));

  assert_pg_loss_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_STAGGER) && !reg3_pgood_i) |=> (rail_en_o == '0 && !cpu_rst_n_o));

  assert_boot_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_boot && !pressed_i && !core_hold_i) |=> (rail_en_o == '0));

  assert_periph_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rail_en_o[NUM_RAILS-1:NUM_CORE]) |-> cpu_rst_n_o);

  assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !pressed_i && !core_hold_i && !periph_en_i) |=> (state_q == ST_OFF));

  assert_irq_only_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_irq_n_o |-> (cpu_rst_n_o && pressed_i));

  assert_vsel_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stby_vsel_o |-> rail_en_o[IDX_REG3]);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl #(
  parameter int TICK_DIV    = 50000,
  parameter int DEB_CYCLES  = 500,
  parameter int RST_MS      = 20,
  parameter int REG1_DLY_MS = 2,
  parameter int REG2_DLY_MS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_n_i,
  input  logic       reg3_pgood_i,
  input  logic       core_hold_i,
  input  logic       periph_en_i,
  input  logic       stby_sel_i,
  output logic [6:0] rail_en_o,
  output logic       cpu_rst_n_o,
  output logic       btn_irq_n_o,
  output logic       stby_vsel_o
);

  logic pressed;
  logic ms_tick;
  logic stagger;

  pwrseq_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_n_i   (btn_n_i),
    .pressed_o (pressed)
  );

  pwrseq_ms_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (stagger),
    .tick_o (ms_tick)
  );

  pwrseq_seq #(
    .RST_MS      (RST_MS),
    .REG1_DLY_MS (REG1_DLY_MS),
    .REG2_DLY_MS (REG2_DLY_MS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pressed_i    (pressed),
    .reg3_pgood_i (reg3_pgood_i),
    .core_hold_i  (core_hold_i),
    .periph_en_i  (periph_en_i),
    .stby_sel_i   (stby_sel_i),
    .tick_i       (ms_tick),
    .stagger_o    (stagger),
    .rail_en_o    (rail_en_o),
    .cpu_rst_n_o  (cpu_rst_n_o),
    .btn_irq_n_o  (btn_irq_n_o),
    .stby_vsel_o  (stby_vsel_o)
  );

endmodule

// File: tb/pwrseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrseq_ctrl_tb_top;

  localparam int TD   = 4;
  localparam int DEB  = 3;
  localparam int RSTM = 10;
  localparam int D1   = 2;
  localparam int D2   = 4;
  localparam int WIN  = RSTM * TD;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn_n;
  logic       pg3;
  logic       hold;
  logic       pen;
  logic       vsel_in;
  logic [6:0] rail_en;
  logic       cpu_rst_n;
  logic       irq_n;
  logic       vsel_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pwrseq_ctrl #(
    .TICK_DIV(TD), .DEB_CYCLES(DEB), .RST_MS(RSTM),
    .REG1_DLY_MS(D1), .REG2_DLY_MS(D2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_n_i(btn_n), .reg3_pgood_i(pg3),
    .core_hold_i(hold), .periph_en_i(pen), .stby_sel_i(vsel_in),
    .rail_en_o(rail_en), .cpu_rst_n_o(cpu_rst_n),
    .btn_irq_n_o(irq_n), .stby_vsel_o(vsel_out)
  );

  // Expected enables k clocks after the power-good edge of the third rail.
  function automatic logic [6:0] exp_stagger(input int k);
    logic [6:0] r;
    r = 7'b0000100;
    if (k >= D1 * TD) r[0] = 1'b1;
    if (k >= D2 * TD) r[1] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_rst_n(input int k);
    return k >= WIN;
  endfunction

  function automatic logic [6:0] exp_run(input logic en);
    return {{4{en}}, 3'b111};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; btn_n = 1'b1; pg3 = 1'b0; hold = 1'b0; pen = 1'b0; vsel_in = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    check("R1 reset rails", rail_en, 7'b0);
    check("R1 reset cpu_rst_n", cpu_rst_n, 0);
    check("R1 reset irq_n", irq_n, 1);
    check("R10 reset vsel", vsel_out, 0);

    // R2 short glitch ignored
    btn_n = 1'b0; step(1); btn_n = 1'b1;
    step(12);
    check("R2 glitch rails", rail_en, 7'b0);

    // R1 press from off enables only the third rail
    btn_n = 1'b0;
    step(10);
    check("R1 press rails", rail_en, 7'b0000100);
    check("R1 press cpu_rst_n", cpu_rst_n, 0);
    check("R9 boot irq_n", irq_n, 1);

    // R3/R4 timed stagger from power-good
    pg3 = 1'b1;
    for (int k = 0; k <= WIN; k++) begin
      step(1);
      check("R3 stagger rails", rail_en, exp_stagger(k));
      check("R4 reset timing", cpu_rst_n, exp_rst_n(k));
    end
    check("R9 press in run irq_n", irq_n, 0);

    // hold before release keeps the system up
    hold = 1'b1;
    step(2);
    btn_n = 1'b1;
    step(10);
    check("R7 hold after release", rail_en, exp_run(1'b0));
    check("R9 released irq_n", irq_n, 1);

    // R7/R10 random hold and enable patterns in normal operation
    for (int i = 0; i < 40; i++) begin
      logic h, e, v;
      h = 1'($urandom_range(0, 1));
      e = 1'($urandom_range(0, 1));
      v = 1'($urandom_range(0, 1));
      if (!h && !e) h = 1'b1;
      hold = h; pen = e; vsel_in = v;
      step(2);
      check("R7 run rails", rail_en, exp_run(e));
      check("R7 run cpu_rst_n", cpu_rst_n, 1);
      check("R10 run vsel", vsel_out, v);
    end

    // R7 button alone keeps core rails up
    btn_n = 1'b0; step(10);
    hold = 1'b0; pen = 1'b0; vsel_in = 1'b0;
    step(3);
    check("R7 button holds core", rail_en, exp_run(1'b0));
    check("R9 press irq_n", irq_n, 0);

    // R8 software shutdown
    btn_n = 1'b1;
    step(12);
    check("R8 shutdown rails", rail_en, 7'b0);
    check("R8 shutdown cpu_rst_n", cpu_rst_n, 0);
    check("R10 off vsel", vsel_out, 0);

    // R6 boot abort without hold
    pg3 = 1'b0;
    btn_n = 1'b0; step(10);
    pg3 = 1'b1; step(4);
    btn_n = 1'b1;
    step(12);
    check("R6 abort rails", rail_en, 7'b0);
    check("R6 abort cpu_rst_n", cpu_rst_n, 0);

    // R5/R4 power-good loss at random points of the stagger
    for (int it = 0; it < 6; it++) begin
      int d;
      d = (it == 5) ? WIN - 1 : int'($urandom_range(0, WIN - 1));
      pg3 = 1'b0; hold = 1'b1; pen = 1'b0;
      btn_n = 1'b0; step(10);
      check("R1 restart rails", rail_en, 7'b0000100);
      pg3 = 1'b1;
      step(1 + d);
      check("R3 before loss", rail_en, exp_stagger(d));
      pg3 = 1'b0;
      step(1);
      check("R5 loss rails", rail_en, 7'b0);
      check("R4 loss cpu_rst_n", cpu_rst_n, 0);
      btn_n = 1'b1; hold = 1'b0;
      step(12);
      check("R6 idle after loss", rail_en, 7'b0);
    end

    summary();
  end

endmodule